// File: doc/BRIEF.md
# Data-Port Address Decoder with Word RAM and Simple I/O

This block is the whole system bus behind the data port of a small single-cycle processor. Each cycle the core presents one byte address together with a write strobe, write data and a read request. The block decides which target the access is for: a 2048-word data RAM in a low window, an output register that drives LEDs, an input register that captures switch levels, or the register window of an interrupt controller on a high device page. Loads get their word back in the same cycle, taken from the selected target.

The RAM array and the two I/O registers are inside the block. Accesses in the interrupt window go out on a select, an offset and a read/write strobe pair, and the controller returns its read word on its own input. Any address that no target owns reads as zero, and writes to it change nothing. The LED register can only be written and the switch register can only be read.

Top module: `sysbus_decoder`

## Requirements
- R1: Byte addresses 0x00002000 to 0x00003FFF select the data RAM; word index = (address - 0x2000) >> 2, so the window holds 2048 words and address bits [1:0] are ignored. A write with bus_we high takes effect at the next rising clock edge. A read with bus_re high returns the stored word in the same cycle, with no clock edge in between.
- R2: The RAM window has hard edges: reads of 0x00001FFC and 0x00004000 return 0, and writes to them leave every RAM word unchanged (no aliasing).
- R3: A write to 0xFFFF0000 loads bus_wdata into led_out at the next rising edge; led_out is 0 after reset.
- R4: A read of 0xFFFF0000 returns 0.
- R5: The switch register at 0xFFFF0004 captures sw_in at every rising edge and reads back the captured value; it reads 0 while reset is held.
- R6: A write to 0xFFFF0004 has no effect: led_out does not change, and the switch register still reads the captured sw_in.
- R7: Byte addresses 0xFFFF0080 to 0xFFFF0107 (bits [1:0] ignored) drive irq_sel high, irq_off = address bits [8:2], irq_we = bus_we, irq_re = bus_re and irq_wdata = bus_wdata; a read there returns irq_rdata. irq_sel is low for 0xFFFF007C and 0xFFFF0108, and irq_we and irq_re are never high while irq_sel is low.
- R8: Every other address reads 0 and ignores writes (for example 0xFFFF0008, 0xFFFF0108, 0x00000000, 0xFFFE0000).
- R9: bus_rdata is 0 in every cycle where bus_re is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| bus_addr | input | 32 | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read request |
| bus_rdata | output | 32 | Read data from the selected target |
| sw_in | input | 32 | Switch levels |
| led_out | output | 32 | LED register contents |
| irq_sel | output | 1 | Access falls in the interrupt register window |
| irq_we | output | 1 | Write strobe toward the interrupt controller |
| irq_re | output | 1 | Read strobe toward the interrupt controller |
| irq_off | output | 7 | Word offset, address bits [8:2] |
| irq_wdata | output | 32 | Write data toward the interrupt controller |
| irq_rdata | input | 32 | Read data from the interrupt controller |

## Verification
A decode fault shows up at the ports in the same cycle as the access: a load returns a word from the wrong target, or zero where data was expected. A fault on the write side is more hidden. A stray RAM write or an aliased index stays invisible until that word is read again, so the bench writes a distinct value to every RAM word before it reads any of them back, and it reads the whole array again after the boundary and device writes. A wrong LED register value is visible at led_out one edge after the write.

// File: rtl/sysbus_pkg.sv
package sysbus_pkg;
  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_RAM  = 3'd1,
    TGT_LED  = 3'd2,
    TGT_SW   = 3'd3,
    TGT_IRQ  = 3'd4
  } tgt_e;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 32;
endpackage

// File: rtl/sysbus_rst_sync.sv
module sysbus_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sysbus_addr_map.sv
module sysbus_addr_map
  import sysbus_pkg::*;
#(
  parameter logic [31:0] RAM_BASE  = 32'h0000_2000,
  parameter int unsigned RAM_WORDS = 2048,
  parameter logic [15:0] DEV_PAGE  = 16'hFFFF,
  parameter logic [15:0] IO_END    = 16'h0080,
  parameter logic [15:0] IRQ_FIRST = 16'h0080,
  parameter logic [15:0] IRQ_LAST  = 16'h0104,
  parameter int unsigned LED_SLOT  = 0,
  parameter int unsigned SW_SLOT   = 1
) (
  input  logic [ADDR_W-1:0]            addr,
  output tgt_e                         tgt,
  output logic [$clog2(RAM_WORDS)-1:0] ram_idx,
  output logic [6:0]                   irq_off
);
  localparam int unsigned IDX_W   = $clog2(RAM_WORDS);
  localparam logic [32:0] RAM_END = {1'b0, RAM_BASE} + 33'(RAM_WORDS) * 33'd4;

  logic [ADDR_W-1:0] word_addr;
  logic [ADDR_W-1:0] ram_diff;
  logic [15:0]       dev_off;
  logic [4:0]        io_slot;
  logic              in_ram;
  logic              in_dev;
  logic              in_io;
  logic              in_irq;

  always_comb begin
    word_addr = {addr[ADDR_W-1:2], 2'b00};
    ram_diff  = word_addr - RAM_BASE;
    in_ram    = (word_addr >= RAM_BASE) && ({1'b0, word_addr} < RAM_END);
    in_dev    = (word_addr[31:16] == DEV_PAGE);
    dev_off   = word_addr[15:0];
    in_io     = in_dev && (dev_off < IO_END);
    in_irq    = in_dev && (dev_off >= IRQ_FIRST) && (dev_off <= IRQ_LAST);
    io_slot   = dev_off[6:2];
    ram_idx   = ram_diff[IDX_W+1:2];
    irq_off   = word_addr[8:2];

    tgt = TGT_NONE;
    if (in_ram) begin
      tgt = TGT_RAM;
    end else if (in_io) begin
      if (io_slot == 5'(LED_SLOT))     tgt = TGT_LED;
      else if (io_slot == 5'(SW_SLOT)) tgt = TGT_SW;
    end else if (in_irq) begin
      tgt = TGT_IRQ;
    end
  end
endmodule

// File: rtl/sysbus_ram.sv
module sysbus_ram #(
  parameter int unsigned WORDS = 2048,
  parameter int unsigned WIDTH = 32
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(WORDS)-1:0] idx,
  input  logic [WIDTH-1:0]         wdata,
  output logic [WIDTH-1:0]         rdata
);
  logic [WIDTH-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/sysbus_io_regs.sv
module sysbus_io_regs #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             led_wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] sw_in,
  output logic [WIDTH-1:0] led_q,
  output logic [WIDTH-1:0] sw_q
);
  logic [WIDTH-1:0] led_d;
  logic [WIDTH-1:0] sw_d;
  logic             sw_en;

  always_comb begin
    led_d = wdata;
    sw_d  = sw_in;
    sw_en = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      led_q <= '0;
    else if (led_wr) led_q <= led_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sw_q <= '0;
    else if (sw_en) sw_q <= sw_d;
  end
endmodule

// File: rtl/sysbus_decoder.sv
module sysbus_decoder
  import sysbus_pkg::*;
#(
  parameter logic [31:0] RAM_BASE  = 32'h0000_2000,
  parameter int unsigned RAM_WORDS = 2048,
  parameter logic [15:0] DEV_PAGE  = 16'hFFFF,
  parameter logic [15:0] IRQ_FIRST = 16'h0080,
  parameter logic [15:0] IRQ_LAST  = 16'h0104
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  input  logic        bus_re,
  output logic [31:0] bus_rdata,
  input  logic [31:0] sw_in,
  output logic [31:0] led_out,
  output logic        irq_sel,
  output logic        irq_we,
  output logic        irq_re,
  output logic [6:0]  irq_off,
  output logic [31:0] irq_wdata,
  input  logic [31:0] irq_rdata
);
  localparam int unsigned IDX_W = $clog2(RAM_WORDS);

  logic             rst_n_sync;
  tgt_e             tgt;
  logic [IDX_W-1:0] ram_idx;
  logic [31:0]      ram_rdata;
  logic [31:0]      sw_q;
  logic             ram_wr;
  logic             led_wr;

  sysbus_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  sysbus_addr_map #(
    .RAM_BASE  (RAM_BASE),
    .RAM_WORDS (RAM_WORDS),
    .DEV_PAGE  (DEV_PAGE),
    .IRQ_FIRST (IRQ_FIRST),
    .IRQ_LAST  (IRQ_LAST)
  ) u_map (
    .addr    (bus_addr),
    .tgt     (tgt),
    .ram_idx (ram_idx),
    .irq_off (irq_off)
  );

  always_comb begin
    ram_wr    = bus_we && (tgt == TGT_RAM);
    led_wr    = bus_we && (tgt == TGT_LED);
    irq_sel   = (tgt == TGT_IRQ);
    irq_we    = bus_we && irq_sel;
    irq_re    = bus_re && irq_sel;
    irq_wdata = bus_wdata;
  end

  sysbus_ram #(.WORDS(RAM_WORDS), .WIDTH(DATA_W)) u_ram (
    .clk   (clk),
    .wr_en (ram_wr),
    .idx   (ram_idx),
    .wdata (bus_wdata),
    .rdata (ram_rdata)
  );

  sysbus_io_regs #(.WIDTH(DATA_W)) u_io (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .led_wr (led_wr),
    .wdata  (bus_wdata),
    .sw_in  (sw_in),
    .led_q  (led_out),
    .sw_q   (sw_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      unique case (tgt)
        TGT_RAM: bus_rdata = ram_rdata;
        TGT_SW:  bus_rdata = sw_q;
        TGT_IRQ: bus_rdata = irq_rdata;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sysbus_decoder_chk.sv
module sysbus_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] bus_addr,
  input logic        bus_we,
  input logic [31:0] bus_wdata,
  input logic        bus_re,
  input logic [31:0] bus_rdata,
  input logic [31:0] led_out,
  input logic        irq_sel,
  input logic        irq_we,
  input logic        irq_re,
  input logic [31:0] irq_rdata
);
  logic led_hit;
  assign led_hit = (bus_addr[31:2] == 30'h3FFF_C000);

  assert_led_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && led_hit) |=> (led_out == $past(bus_wdata)));

  assert_led_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && led_hit) |=> $stable(led_out));

  assert_led_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && led_hit) |-> (bus_rdata == 32'h0));

  assert_idle_rdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |-> (bus_rdata == 32'h0));

  assert_irq_strobes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_sel |-> (!irq_we && !irq_re));

  assert_irq_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_sel && bus_re) |-> (bus_rdata == irq_rdata));
endmodule

bind sysbus_decoder sysbus_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .led_out   (led_out),
  .irq_sel   (irq_sel),
  .irq_we    (irq_we),
  .irq_re    (irq_re),
  .irq_rdata (irq_rdata)
);

// File: tb/tb_sysbus_decoder.sv
module tb_sysbus_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 2048;

  logic        clk;
  logic        rst_n;
  logic [31:0] bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic        bus_re;
  logic [31:0] bus_rdata;
  logic [31:0] sw_in;
  logic [31:0] led_out;
  logic        irq_sel;
  logic        irq_we;
  logic        irq_re;
  logic [6:0]  irq_off;
  logic [31:0] irq_wdata;
  logic [31:0] irq_rdata;

  int errors;
  int checks;
  int cycles;

  sysbus_decoder dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .sw_in(sw_in), .led_out(led_out), .irq_sel(irq_sel), .irq_we(irq_we),
    .irq_re(irq_re), .irq_off(irq_off), .irq_wdata(irq_wdata),
    .irq_rdata(irq_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // interrupt controller stand-in: read word depends on the offset
  assign irq_rdata = 32'hC0DE_0000 | {25'h0, irq_off};

  function automatic logic [31:0] pat(input int i, input logic [31:0] salt);
    return (32'(i) * 32'h9E37_79B1) ^ salt ^ {32'(i)}[31:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; bus_re = 1'b0;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic do_read(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0; bus_re = 1'b1;
    #1;
    d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] led_exp;
    int          mism;
    errors = 0; checks = 0; cycles = 0;
    bus_addr = '0; bus_we = 0; bus_wdata = '0; bus_re = 0;
    sw_in = 32'hA5A5_0F0F;
    rst_n = 1'b0;

    // reset state
    repeat (3) @(negedge clk);
    check("R3 led_out in reset", led_out, 32'h0);
    bus_addr = 32'hFFFF_0004; bus_re = 1'b1; #1;
    check("R5 switch reads 0 in reset", bus_rdata, 32'h0);
    bus_re = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: idle bus returns zero
    bus_addr = 32'h0000_2000; #1;
    check("R9 rdata with re low", bus_rdata, 32'h0);

    // R1: fill every RAM word, then read each one back
    for (int i = 0; i < WORDS; i++) do_write(32'h2000 + 32'(i) * 4, pat(i, 32'h1111_0000));
    mism = 0;
    for (int i = 0; i < WORDS; i++) begin
      do_read(32'h2000 + 32'(i) * 4, rd);
      if (rd !== pat(i, 32'h1111_0000)) begin
        mism++;
        if (mism < 5) check("R1 ram word", rd, pat(i, 32'h1111_0000));
      end
    end
    check("R1 ram sweep mismatches", 32'(mism), 32'h0);

    // R1: low address bits ignored
    do_write(32'h0000_2007, 32'hDEAD_0001);
    do_read(32'h0000_2004, rd);
    check("R1 unaligned write hits word 1", rd, 32'hDEAD_0001);
    do_read(32'h0000_3FFE, rd);
    check("R1 top word, low bits ignored", rd, pat(WORDS-1, 32'h1111_0000));

    // R2: edges of the window
    do_read(32'h0000_1FFC, rd);
    check("R2 read below window", rd, 32'h0);
    do_read(32'h0000_4000, rd);
    check("R2 read above window", rd, 32'h0);
    do_write(32'h0000_1FFC, 32'hBAD0_BAD0);
    do_write(32'h0000_4000, 32'hBAD1_BAD1);

    // R3/R4: LED register
    led_exp = 32'h0;
    check("R3 led_out after reset", led_out, led_exp);
    do_write(32'hFFFF_0000, 32'h1234_5678);
    led_exp = 32'h1234_5678;
    check("R3 led_out after write", led_out, led_exp);
    do_read(32'hFFFF_0000, rd);
    check("R4 led read returns 0", rd, 32'h0);
    do_write(32'hFFFF_0003, 32'h0F0F_F0F0);
    led_exp = 32'h0F0F_F0F0;
    check("R3 led write low bits ignored", led_out, led_exp);

    // R5/R6: switch register
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      sw_in = pat(k, 32'h5A5A_A5A5);
      @(negedge clk);
      do_read(32'hFFFF_0004, rd);
      check("R5 switch captured", rd, pat(k, 32'h5A5A_A5A5));
    end
    do_write(32'hFFFF_0004, 32'hFFFF_FFFF);
    check("R6 switch write leaves led", led_out, led_exp);
    do_read(32'hFFFF_0004, rd);
    check("R6 switch still reads sw_in", rd, sw_in);

    // R7: interrupt window
    for (int off = 'h7C; off <= 'h108; off += 4) begin
      logic exp_sel;
      exp_sel = (off >= 'h80) && (off <= 'h104);
      @(negedge clk);
      bus_addr = 32'hFFFF_0000 | 32'(off); bus_re = 1'b1; bus_we = 1'b0;
      bus_wdata = 32'h0BAD_0000 | 32'(off);
      #1;
      check("R7 irq_sel", {31'h0, irq_sel}, {31'h0, exp_sel});
      check("R7 irq_re", {31'h0, irq_re}, {31'h0, exp_sel});
      check("R7 irq_we idle", {31'h0, irq_we}, 32'h0);
      if (exp_sel) begin
        check("R7 irq_off", {25'h0, irq_off}, 32'(off >> 2));
        check("R7 irq read data", bus_rdata, 32'hC0DE_0000 | 32'(off >> 2));
        check("R7 irq_wdata", irq_wdata, 32'h0BAD_0000 | 32'(off));
      end else begin
        check("R8 read outside irq window", bus_rdata, 32'h0);
      end
      bus_re = 1'b0; bus_we = 1'b1; #1;
      check("R7 irq_we on write", {31'h0, irq_we}, {31'h0, exp_sel});
      bus_we = 1'b0;
    end

    // R8: other unmapped addresses
    do_read(32'hFFFF_0008, rd);
    check("R8 unused io slot reads 0", rd, 32'h0);
    do_read(32'h0000_0000, rd);
    check("R8 address 0 reads 0", rd, 32'h0);
    do_read(32'hFFFE_0000, rd);
    check("R8 other page reads 0", rd, 32'h0);
    do_write(32'hFFFF_0008, 32'h7777_7777);
    do_write(32'hFFFE_0000, 32'h6666_6666);
    do_write(32'h0000_0000, 32'h5555_5555);
    check("R8 unmapped writes leave led", led_out, led_exp);

    // R2/R8: no stray write reached RAM
    mism = 0;
    for (int i = 0; i < WORDS; i++) begin
      logic [31:0] e;
      e = (i == 1) ? 32'hDEAD_0001 : pat(i, 32'h1111_0000);
      do_read(32'h2000 + 32'(i) * 4, rd);
      if (rd !== e) begin
        mism++;
        if (mism < 5) check("R2 ram word after stray writes", rd, e);
      end
    end
    check("R2 ram unchanged by outside writes", 32'(mism), 32'h0);

    finish_run();
  end
endmodule